// File: doc/BRIEF.md
# Multiplexed CPU Bus Target Interface

This block is the target side of a 64-bit processor bus on which address and data share the same wires. A separate 9-bit command bus qualifies every cycle, and an 8-bit check bus carries byte parity. The master puts the address on the shared bus for a single cycle, together with a command word that gives the direction and the burst length. After that, it either drives write beats or releases the bus so the target can return read beats. The meaning of the command word depends on whether the cycle is an address cycle or a data cycle.

Write beats are passed straight to a memory-style request port. Read beats are fetched from the same port, which has a fixed read latency of one clock. They go back onto the bus after one idle turnaround cycle, and during those beats the block drives the command and check buses itself. Bursts of one to four 64-bit words are supported in both directions. Illegal command words and write bursts of the wrong length raise a protocol-error pulse. Write beats with bad parity or a bad-data tag are stored with an error flag.

Top module: `cpubus_target`

## Requirements
- R1: After reset the block drives none of the shared buses (`busAdOe`=0, `cmdOe`=0), makes no memory request, and raises no `protoErr`.
- R2: An address cycle is a valid cycle (`validIn`=1) taken in idle with cmd[8]=0, cmd[7]=0 and cmd[5]=0. cmd[6] gives the direction (1 = write, 0 = read) and cmd[4:0] gives the beat count minus one. The word address is `busAdIn[ADDR_W+2:3]`, and the first beat uses that word address on `memAddr`.
- R3: A write data beat is a valid cycle with cmd[8]=1 and cmd[6]=0. Each such beat issues a memory write (`memReq`=1, `memWe`=1) in the same cycle, carrying the bus data. Successive beats use consecutive word addresses.
- R4: Parity is even per byte: check bit i equals the XOR of data bits 8i+7..8i. A write beat whose check bits mismatch, or that has cmd[5]=1, is written with `memWerr`=1, and `dataErr` pulses in that same cycle.
- R5: Some codes are reserved. In an address cycle, these are cmd[8]=1, cmd[7]=1, cmd[5]=1 or cmd[4:0] above 3. In a write data cycle, these are cmd[8]=0 or cmd[6]=1. A reserved code pulses `protoErr` in that cycle, makes no memory access, and returns the block to idle.
- R6: A write beat tagged last (cmd[7]=1) before the expected final beat pulses `protoErr` in that beat. So does an expected final beat that is not tagged last. In both cases the beat is still written and the transaction ends.
- R7: In the cycle after a read address cycle, the block leaves the buses undriven. The N read beats are then driven in the N following consecutive cycles.
- R8: On a read beat, `cmdOut` has bit 8=1, bit 6=0 and bits 4:0=0. Bit 7 is 1 only on the final beat. Bit 5 copies the store's error flag for that word. `chkOut` is the even byte parity of `busAdOut`.
- R9: Bursts of 1, 2, 3 and 4 beats work for both reads and writes, and read data matches what was written at each address.
- R10: After a read or write ends, normally or aborted, the block is idle in the next cycle and releases the buses. There it accepts a new address cycle, and it treats a data-coded cycle as reserved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Master drives an address or write-data cycle |
| busAdIn | input | 64 | Shared address/data bus, master side |
| cmdIn | input | 9 | Command word from master |
| chkIn | input | 8 | Byte parity from master |
| busAdOut | output | 64 | Read data driven by the target |
| busAdOe | output | 1 | Target drives the shared bus |
| cmdOut | output | 9 | Command word driven on read beats |
| cmdOe | output | 1 | Target drives the command bus |
| chkOut | output | 8 | Byte parity of read data |
| protoErr | output | 1 | Protocol violation pulse |
| dataErr | output | 1 | Erroneous write beat pulse |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 16 | Memory word address |
| memWdata | output | 64 | Memory write data |
| memWerr | output | 1 | Write beat is marked erroneous |
| memRdata | input | 64 | Memory read data, one cycle after request |
| memRerr | input | 1 | Error flag of read word |

## Verification
All write-side results appear combinationally in the same cycle as the beat that causes them: the memory strobes, address and data, `memWerr`, `dataErr` and `protoErr`. A reserved address code likewise shows `protoErr` in its own cycle. For a read whose address is presented in cycle A, cycle A+1 is undriven, and beat i appears in cycle A+2+i. The bus is released again in cycle A+2+N. The bench applies every input just after a falling edge and samples 1 ns later, so each check sees the state left by the previous rising edge combined with the inputs of the current cycle.

// File: rtl/cpubus_pkg.sv
package cpubus_pkg;
  localparam int BUS_W = 64;
  localparam int LANES = BUS_W / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_WDATA, ST_RTURN, ST_RDATA} busState_t;

  typedef struct packed {
    logic capAddr;
    logic incAddr;
    logic memReq;
    logic memWe;
    logic driveRead;
    logic lastBeat;
  } dpCtl_t;

  function automatic logic [LANES-1:0] laneParity(input logic [BUS_W-1:0] d);
    logic [LANES-1:0] p;
    for (int i = 0; i < LANES; i++) p[i] = ^d[8*i +: 8];
    return p;
  endfunction
endpackage

// File: rtl/cpubus_ctrl.sv
module cpubus_ctrl
  import cpubus_pkg::*;
#(
  parameter int MAX_BEATS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         validIn,
  input  logic [8:0]   cmdIn,
  output dpCtl_t       ctl,
  output logic         protoErr
);
  localparam int CNT_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
  localparam logic [4:0] SIZE_MAX = 5'(MAX_BEATS - 1);

  busState_t state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt, lastIdx, lastNxt;
  logic addrBad, dataBad, atEnd;

  assign addrBad = cmdIn[8] | cmdIn[7] | cmdIn[5] | (cmdIn[4:0] > SIZE_MAX);
  assign dataBad = ~cmdIn[8] | cmdIn[6];
  assign atEnd   = (cnt == lastIdx);

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    lastNxt  = lastIdx;
    ctl      = '0;
    protoErr = 1'b0;
    unique case (state)
      ST_IDLE: if (validIn) begin
        if (addrBad) begin
          protoErr = 1'b1;
        end else begin
          ctl.capAddr = 1'b1;
          cntNxt      = '0;
          lastNxt     = cmdIn[CNT_W-1:0];
          stateNxt    = cmdIn[6] ? ST_WDATA : ST_RTURN;
        end
      end
      ST_WDATA: if (validIn) begin
        if (dataBad) begin
          protoErr = 1'b1;
          stateNxt = ST_IDLE;
        end else begin
          ctl.memReq  = 1'b1;
          ctl.memWe   = 1'b1;
          ctl.incAddr = 1'b1;
          cntNxt      = cnt + CNT_W'(1);
          if (cmdIn[7] || atEnd) stateNxt = ST_IDLE;
          protoErr = cmdIn[7] ^ atEnd;
        end
      end
      ST_RTURN: begin
        ctl.memReq  = 1'b1;
        ctl.incAddr = 1'b1;
        cntNxt      = '0;
        stateNxt    = ST_RDATA;
      end
      ST_RDATA: begin
        ctl.driveRead = 1'b1;
        ctl.lastBeat  = atEnd;
        if (atEnd) begin
          stateNxt = ST_IDLE;
        end else begin
          ctl.memReq  = 1'b1;
          ctl.incAddr = 1'b1;
          cntNxt      = cnt + CNT_W'(1);
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      lastIdx <= '0;
    end else begin
      state   <= stateNxt;
      cnt     <= cntNxt;
      lastIdx <= lastNxt;
    end
  end

  // R7: a read address cycle is followed by an undriven turnaround cycle
  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && validIn && !addrBad && !cmdIn[6]) |=> (state == ST_RTURN && !ctl.driveRead));

  // R5: a protocol error always leaves the block idle
  p_abort_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> (state == ST_IDLE));

  // R9: the beat counter never runs past the requested burst length
  p_beat_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (cnt <= lastIdx));

  // R10: the final read beat is followed by a released bus
  p_read_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.driveRead && ctl.lastBeat) |=> !ctl.driveRead);
endmodule

// File: rtl/cpubus_dp.sv
module cpubus_dp
  import cpubus_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [BUS_W-1:0]  busAdIn,
  input  logic [LANES-1:0]  chkIn,
  input  logic              cmdErrTag,
  input  logic [BUS_W-1:0]  memRdata,
  input  logic              memRerr,
  output logic [BUS_W-1:0]  busAdOut,
  output logic              busAdOe,
  output logic [8:0]        cmdOut,
  output logic              cmdOe,
  output logic [LANES-1:0]  chkOut,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BUS_W-1:0]  memWdata,
  output logic              memWerr,
  output logic              dataErr
);
  logic [ADDR_W-1:0] addrReg;
  logic parMis;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            addrReg <= '0;
    else if (ctl.capAddr) addrReg <= busAdIn[ADDR_W+2:3];
    else if (ctl.incAddr) addrReg <= addrReg + ADDR_W'(1);
  end

  assign parMis   = (chkIn != laneParity(busAdIn));
  assign memReq   = ctl.memReq;
  assign memWe    = ctl.memWe;
  assign memAddr  = addrReg;
  assign memWdata = busAdIn;
  assign memWerr  = ctl.memWe & (cmdErrTag | parMis);
  assign dataErr  = ctl.memReq & memWerr;

  assign busAdOe  = ctl.driveRead;
  assign cmdOe    = ctl.driveRead;
  assign busAdOut = ctl.driveRead ? memRdata : '0;
  assign chkOut   = ctl.driveRead ? laneParity(memRdata) : '0;
  assign cmdOut   = ctl.driveRead ? {1'b1, ctl.lastBeat, 1'b0, memRerr, 5'b0} : 9'b0;

  // R3: the target never drives the bus while a write beat is being taken
  p_no_clash_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memReq && ctl.memWe) |-> !busAdOe);

  // R2: the first memory access of a transaction uses the captured address
  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capAddr |=> (memAddr == $past(busAdIn[ADDR_W+2:3])));
endmodule

// File: rtl/cpubus_target.sv
module cpubus_target
  import cpubus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MAX_BEATS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [63:0]       busAdIn,
  input  logic [8:0]        cmdIn,
  input  logic [7:0]        chkIn,
  output logic [63:0]       busAdOut,
  output logic              busAdOe,
  output logic [8:0]        cmdOut,
  output logic              cmdOe,
  output logic [7:0]        chkOut,
  output logic              protoErr,
  output logic              dataErr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memWdata,
  output logic              memWerr,
  input  logic [63:0]       memRdata,
  input  logic              memRerr
);
  dpCtl_t ctl;

  cpubus_ctrl #(.MAX_BEATS(MAX_BEATS)) u_ctrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .cmdIn(cmdIn),
    .ctl(ctl), .protoErr(protoErr)
  );

  cpubus_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busAdIn(busAdIn), .chkIn(chkIn),
    .cmdErrTag(cmdIn[5]), .memRdata(memRdata), .memRerr(memRerr),
    .busAdOut(busAdOut), .busAdOe(busAdOe), .cmdOut(cmdOut), .cmdOe(cmdOe),
    .chkOut(chkOut), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memWerr(memWerr), .dataErr(dataErr)
  );
endmodule

// File: tb/cpubus_target_test.sv
`timescale 1ns/1ps
module cpubus_target_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0;
  logic [63:0] busAdIn = '0;
  logic [8:0] cmdIn = '0;
  logic [7:0] chkIn = '0;
  logic [63:0] busAdOut, memWdata, memRdata;
  logic busAdOe, cmdOe, protoErr, dataErr, memReq, memWe, memWerr, memRerr;
  logic [8:0] cmdOut;
  logic [7:0] chkOut;
  logic [15:0] memAddr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [63:0] store [16];
  logic storeErr [16];
  logic [63:0] shadowD [16];
  logic shadowE [16];

  always #5 clk = ~clk;

  cpubus_target uut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .busAdIn(busAdIn), .cmdIn(cmdIn),
    .chkIn(chkIn), .busAdOut(busAdOut), .busAdOe(busAdOe), .cmdOut(cmdOut),
    .cmdOe(cmdOe), .chkOut(chkOut), .protoErr(protoErr), .dataErr(dataErr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memWerr(memWerr), .memRdata(memRdata), .memRerr(memRerr)
  );

  // backing store with one cycle read latency
  always_ff @(posedge clk) begin
    if (memReq && memWe) begin
      store[memAddr[3:0]]    <= memWdata;
      storeErr[memAddr[3:0]] <= memWerr;
    end
    if (memReq && !memWe) begin
      memRdata <= store[memAddr[3:0]];
      memRerr  <= storeErr[memAddr[3:0]];
    end
  end

  function automatic logic [7:0] par(input logic [63:0] d);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ^d[8*i +: 8];
    return p;
  endfunction

  function automatic logic [63:0] pattern(input int a);
    return {32'hC0DE_0000 + 32'(a), 32'h1234_5678 ^ (32'(a) * 32'h0101_0101)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [63:0] ad, input logic [8:0] cmd, input logic [7:0] chk);
    @(negedge clk);
    validIn = v; busAdIn = ad; cmdIn = cmd; chkIn = chk;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 64'h0, 9'h0, 8'h0);
  endtask

  task automatic t_reset();
    check("R1 busAdOe", 64'(busAdOe), 64'd0);
    check("R1 cmdOe", 64'(cmdOe), 64'd0);
    check("R1 memReq", 64'(memReq), 64'd0);
    check("R1 protoErr", 64'(protoErr), 64'd0);
  endtask

  task automatic t_write(input int addr, input int n, input int badTag, input int badPar);
    drive(1'b1, 64'(addr) << 3, {4'b0010, 5'(n-1)}, 8'h0);
    check("R2 write addr cycle protoErr", 64'(protoErr), 64'd0);
    check("R2 write addr cycle memReq", 64'(memReq), 64'd0);
    for (int i = 0; i < n; i++) begin
      logic [63:0] d;
      logic expErr;
      d = pattern(addr + i);
      expErr = (i == badTag) || (i == badPar);
      drive(1'b1, d, {1'b1, (i == n-1), 1'b0, (i == badTag), 5'b0},
            par(d) ^ ((i == badPar) ? 8'h10 : 8'h00));
      check("R3 write strobe", 64'(memReq && memWe), 64'd1);
      check("R3 write address", 64'(memAddr), 64'(addr + i));
      check("R3 write data", memWdata, d);
      check("R4 memWerr", 64'(memWerr), 64'(expErr));
      check("R4 dataErr", 64'(dataErr), 64'(expErr));
      check("R6 no protoErr on correct length", 64'(protoErr), 64'd0);
      shadowD[(addr+i) % 16] = d;
      shadowE[(addr+i) % 16] = expErr;
    end
    idle();
    check("R10 idle after write", 64'(memReq), 64'd0);
  endtask

  task automatic t_read(input int addr, input int n);
    drive(1'b1, 64'(addr) << 3, {4'b0000, 5'(n-1)}, 8'h0);
    check("R2 read addr cycle protoErr", 64'(protoErr), 64'd0);
    idle();
    check("R7 turnaround undriven", 64'(busAdOe | cmdOe), 64'd0);
    for (int i = 0; i < n; i++) begin
      logic [63:0] d;
      d = shadowD[(addr+i) % 16];
      idle();
      check("R7 read beat driven", 64'(busAdOe && cmdOe), 64'd1);
      check("R9 read data", busAdOut, d);
      check("R8 read cmd", 64'(cmdOut),
            64'({1'b1, (i == n-1), 1'b0, shadowE[(addr+i) % 16], 5'b0}));
      check("R8 read parity", 64'(chkOut), 64'(par(d)));
    end
    idle();
    check("R10 bus released after read", 64'(busAdOe | cmdOe), 64'd0);
  endtask

  task automatic t_reserved();
    drive(1'b1, 64'h0, 9'h080, 8'h0);
    check("R5 addr bit7 protoErr", 64'(protoErr), 64'd1);
    check("R5 addr bit7 no access", 64'(memReq), 64'd0);
    drive(1'b1, 64'h0, 9'h100, 8'h0);
    check("R5 data code in idle protoErr", 64'(protoErr), 64'd1);
    drive(1'b1, 64'h0, 9'h020, 8'h0);
    check("R5 addr bit5 protoErr", 64'(protoErr), 64'd1);
    drive(1'b1, 64'h0, 9'h004, 8'h0);
    check("R5 size code 4 protoErr", 64'(protoErr), 64'd1);
    drive(1'b1, 64'(3) << 3, 9'h041, 8'h0);
    check("R5 legal write addr", 64'(protoErr), 64'd0);
    drive(1'b1, 64'h55, 9'h140, par(64'h55));
    check("R5 data bit6 protoErr", 64'(protoErr), 64'd1);
    check("R5 data bit6 no access", 64'(memReq), 64'd0);
    drive(1'b1, 64'h55, 9'h180, par(64'h55));
    check("R10 aborted write is idle", 64'(protoErr), 64'd1);
    check("R10 aborted write no access", 64'(memReq), 64'd0);
  endtask

  task automatic t_length();
    logic [63:0] d;
    // early last: expect 3 beats, last on the second
    drive(1'b1, 64'(4) << 3, 9'h042, 8'h0);
    d = pattern(4);
    drive(1'b1, d, 9'h100, par(d));
    check("R6 first beat fine", 64'(protoErr), 64'd0);
    shadowD[4] = d; shadowE[4] = 1'b0;
    d = pattern(5) ^ 64'hFF;
    drive(1'b1, d, 9'h180, par(d));
    check("R6 early last protoErr", 64'(protoErr), 64'd1);
    check("R6 early last still written", 64'(memReq && memWe), 64'd1);
    shadowD[5] = d; shadowE[5] = 1'b0;
    t_read(4, 2);
    // missing last: expect 2 beats, none tagged last
    drive(1'b1, 64'(6) << 3, 9'h041, 8'h0);
    d = pattern(6);
    drive(1'b1, d, 9'h100, par(d));
    shadowD[6] = d; shadowE[6] = 1'b0;
    d = pattern(7) ^ 64'hF0F0;
    drive(1'b1, d, 9'h100, par(d));
    check("R6 missing last protoErr", 64'(protoErr), 64'd1);
    check("R6 missing last still written", 64'(memReq && memWe), 64'd1);
    shadowD[7] = d; shadowE[7] = 1'b0;
    drive(1'b1, d, 9'h180, par(d));
    check("R10 transaction ended after missing last", 64'(protoErr), 64'd1);
    check("R10 no write after end", 64'(memReq), 64'd0);
    t_read(6, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    #1;
    t_reset();
    t_write(0, 4, -1, -1);
    t_read(0, 4);
    t_write(8, 2, 1, -1);
    t_write(12, 1, -1, 0);
    t_write(13, 3, -1, -1);
    t_read(8, 2);
    t_read(12, 1);
    t_read(13, 3);
    t_read(1, 3);
    t_reserved();
    t_length();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule